// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block turns each bus cycle into a chip-select for one of several address windows. Each channel holds a base word and a mask word. The base word gives the window's upper address bits and a function-code value, plus control flags: valid, CPU-space suppression, write protection and extended delay. The mask word gives per-bit don't-care masks for the address and the function code, plus a two-bit delay field.

When address strobe is seen, every channel compares the bus address bits 31..8 and the 4-bit function code against its window. The lowest-numbered matching channel wins. On the next clock edge the block produces one of two results. A protected write produces a bus error. Any other hit asserts the winner's chip-select and, after a programmed number of wait states, a one-clock internal acknowledge.

Software programs the channels through a simple word-wide write/read port. The port selects a channel by index and chooses the base or the mask word.

Top module: `csd_top`

## Requirements
- R1: A channel's address matches when bus address bits 31..8 equal base bits 31..8 in every position whose mask bit (mask bits 31..8) is clear. With an all-zero mask the window is 256 bytes.
- R2: The function code matches when `bus_fc` equals base bits 3..0 in every position where mask bits 3..0 are clear. A set mask bit lets several address-space types hit one channel.
- R3: With the no-CPU-space flag (base bit 6) set, a cycle whose function code is 4'h7 or 4'hF asserts no chip-select, even when address and function code match.
- R4: With write protect (base bit 5) set, a write (`bus_rw`=0) that hits the channel asserts `berr` and no chip-select. A read to the same window asserts the chip-select. `berr` and any chip-select are never high together.
- R5: A channel whose valid flag (base bit 7) is clear never asserts its chip-select, bus error or acknowledge.
- R6: Reset clears the valid and no-CPU-space flags of every channel. It leaves all other base and mask bits unchanged, as seen through `reg_rdata`.
- R7: The wait count is {base bit 4, mask bits 5..4}: 0..3 with extended delay off, 4..7 with it on. `ack` is high for exactly one clock. That clock is N edges after the edge that first raises the chip-select, so N=0 coincides with it. `ack` is only high while a chip-select is high.
- R8: When several valid channels match, only the lowest-numbered one produces chip-select, bus error or acknowledge. At most one chip-select is high.
- R9: The match is taken on the first rising edge with `bus_as` high. Chip-select and bus error stay constant until `bus_as` is low at an edge, which clears them on that edge.
- R10: `reg_sel`=0 addresses the base word and 1 the mask word of channel `reg_idx`. A write is applied on the clock edge and governs the next bus cycle. `reg_rdata` returns the selected word combinationally. Mask bits 7..6 read as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_idx | input | IW | Channel index for register access |
| reg_sel | input | 1 | 0 selects base word, 1 selects mask word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| bus_as | input | 1 | Address strobe, active high |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_addr | input | 32 | Bus address |
| bus_fc | input | 4 | Bus function code |
| cs | output | NCH | Per-channel chip-selects, active high |
| berr | output | 1 | Bus error for a protected write |
| ack | output | 1 | Internally timed acknowledge pulse |

## Verification
Bus cycles are issued to addresses inside a window, outside it, and just past the 256-byte boundary. These separate the effects of the address mask from those of the base compare. Function codes are swept across the masked and unmasked positions, including 4'h7 and 4'hF with CPU-space suppression toggled. This shows which control gates which decision. Overlapping windows are probed before and after the lower channel is invalidated, to expose priority order. Every wait setting in both delay ranges is timed, so an off-by-one in either range or a lost extended bit shows up as a shifted acknowledge.

// File: rtl/csd_pkg.sv
package csd_pkg;
   localparam int WORD_W = 32;
   localparam int CMP_W  = 24;
   localparam int FC_W   = 4;
   localparam int WAIT_W = 3;

   typedef struct packed {
      logic [CMP_W-1:0] addr;
      logic             valid;
      logic             nocpu;
      logic             wprot;
      logic             ext;
      logic [FC_W-1:0]  fc;
   } base_t;

   typedef struct packed {
      logic [CMP_W-1:0] addr;
      logic [1:0]       spare;
      logic [1:0]       dly;
      logic [FC_W-1:0]  fc;
   } mask_t;
endpackage

// File: rtl/csd_regs.sv
module csd_regs #(
   parameter int NCH = 4,
   parameter int IW  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [IW-1:0]              idx,
   input  logic                       sel,
   input  logic [csd_pkg::WORD_W-1:0] wdata,
   output logic [csd_pkg::WORD_W-1:0] rdata,
   output csd_pkg::base_t             base_o [NCH],
   output csd_pkg::mask_t             mask_o [NCH]
);
   import csd_pkg::*;

   logic [1:0]        ctl_q  [NCH];
   logic [WORD_W-1:0] base_q [NCH];
   logic [WORD_W-1:0] mask_q [NCH];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hit_w;
      assign hit_w = we && (idx == IW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                ctl_q[i] <= 2'b00;
         else if (hit_w && !sel)    ctl_q[i] <= wdata[7:6];
      end

      always_ff @(posedge clk) begin
         if (hit_w && !sel) base_q[i] <= wdata;
         if (hit_w &&  sel) mask_q[i] <= wdata;
      end

      always_comb begin
         base_o[i]       = base_t'(base_q[i]);
         base_o[i].valid = ctl_q[i][1];
         base_o[i].nocpu = ctl_q[i][0];
         mask_o[i]       = mask_t'(mask_q[i]);
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NCH; i++)
         if (idx == IW'(i)) rdata = sel ? mask_o[i] : base_o[i];
   end
endmodule

// File: rtl/csd_match.sv
module csd_match (
   input  csd_pkg::base_t                base,
   input  csd_pkg::mask_t                mask,
   input  logic [csd_pkg::WORD_W-1:0]    addr,
   input  logic [csd_pkg::FC_W-1:0]      fc,
   input  logic                          rw,
   output logic                          hit,
   output logic                          wp_viol,
   output logic [csd_pkg::WAIT_W-1:0]    wait_n
);
   import csd_pkg::*;

   logic addr_ok, fc_ok, cpu_sp;

   always_comb begin
      addr_ok = (((addr[WORD_W-1 -: CMP_W] ^ base.addr) & ~mask.addr) == '0);
      fc_ok   = (((fc ^ base.fc) & ~mask.fc) == '0);
      cpu_sp  = (fc[2:0] == 3'b111);
      hit     = base.valid && addr_ok && fc_ok && !(base.nocpu && cpu_sp);
      wp_viol = base.wprot && !rw;
      wait_n  = {base.ext, mask.dly};
   end
endmodule

// File: rtl/csd_arb.sv
module csd_arb #(
   parameter int NCH = 4
) (
   input  logic [NCH-1:0] req,
   output logic [NCH-1:0] gnt,
   output logic           any
);
   always_comb begin
      gnt = '0;
      for (int i = NCH-1; i >= 0; i--)
         if (req[i]) gnt = NCH'(1) << i;
      any = |req;
   end
endmodule

// File: rtl/csd_top.sv
module csd_top #(
   parameter int NCH = 4,
   parameter int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_we,
   input  logic [IW-1:0]              reg_idx,
   input  logic                       reg_sel,
   input  logic [csd_pkg::WORD_W-1:0] reg_wdata,
   output logic [csd_pkg::WORD_W-1:0] reg_rdata,
   input  logic                       bus_as,
   input  logic                       bus_rw,
   input  logic [csd_pkg::WORD_W-1:0] bus_addr,
   input  logic [csd_pkg::FC_W-1:0]   bus_fc,
   output logic [NCH-1:0]             cs,
   output logic                       berr,
   output logic                       ack
);
   import csd_pkg::*;

   initial begin
      assert (NCH >= 1 && NCH <= 16) else $error("csd_top: NCH out of range");
      assert (IW >= 1 && (1 << IW) >= NCH) else $error("csd_top: IW too narrow");
   end

   base_t             base_w [NCH];
   mask_t             mask_w [NCH];
   logic [NCH-1:0]    hit_v, wpv_v, gnt;
   logic [WAIT_W-1:0] wait_v [NCH];
   logic              any;

   csd_regs #(.NCH(NCH), .IW(IW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx), .sel(reg_sel),
      .wdata(reg_wdata), .rdata(reg_rdata), .base_o(base_w), .mask_o(mask_w));

   for (genvar i = 0; i < NCH; i++) begin : g_m
      csd_match u_m (
         .base(base_w[i]), .mask(mask_w[i]), .addr(bus_addr), .fc(bus_fc),
         .rw(bus_rw), .hit(hit_v[i]), .wp_viol(wpv_v[i]), .wait_n(wait_v[i]));
   end

   csd_arb #(.NCH(NCH)) u_arb (.req(hit_v), .gnt(gnt), .any(any));

   logic [WAIT_W-1:0] win_wait;
   logic              win_wpv, win_ok;
   always_comb begin
      win_wait = '0;
      for (int i = 0; i < NCH; i++)
         if (gnt[i]) win_wait = wait_v[i];
      win_wpv = |(gnt & wpv_v);
      win_ok  = any && !win_wpv;
   end

   logic              act_q, berr_q, ack_q, pend_q;
   logic [NCH-1:0]    cs_q;
   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0; cs_q <= '0; berr_q <= 1'b0;
         ack_q <= 1'b0; pend_q <= 1'b0; cnt_q <= '0;
      end else if (!bus_as) begin
         act_q <= 1'b0; cs_q <= '0; berr_q <= 1'b0;
         ack_q <= 1'b0; pend_q <= 1'b0; cnt_q <= '0;
      end else if (!act_q) begin
         act_q  <= 1'b1;
         cs_q   <= win_ok ? gnt : '0;
         berr_q <= any && win_wpv;
         ack_q  <= win_ok && (win_wait == '0);
         pend_q <= win_ok && (win_wait != '0);
         cnt_q  <= win_wait;
      end else begin
         ack_q <= 1'b0;
         if (pend_q) begin
            if (cnt_q == WAIT_W'(1)) begin
               ack_q  <= 1'b1;
               pend_q <= 1'b0;
            end
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign cs   = cs_q;
   assign berr = berr_q;
   assign ack  = ack_q;
endmodule

// File: rtl/csd_chk.sv
module csd_chk #(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           bus_as,
   input logic [NCH-1:0] cs,
   input logic           berr,
   input logic           ack
);
   a_r8_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs));
   a_r4_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !((|cs) && berr));
   a_r7_ack_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (|cs));
   a_r7_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_as |=> (cs == '0 && !berr && !ack));
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_as && $past(bus_as) && (|cs)) |=> (!bus_as || $stable(cs)));
endmodule

bind csd_top csd_chk #(.NCH(NCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .cs(cs), .berr(berr), .ack(ack));

// File: tb/csd_top_bench.sv
module csd_top_bench;
   localparam int CLK_P = 10;
   localparam int NCH   = 4;
   localparam int IW    = 2;
   localparam int HOLD  = 10;

   logic            clk = 0, rst_n = 0;
   logic            reg_we = 0, reg_sel = 0;
   logic [IW-1:0]   reg_idx = '0;
   logic [31:0]     reg_wdata = '0, reg_rdata;
   logic            bus_as = 0, bus_rw = 1;
   logic [31:0]     bus_addr = '0;
   logic [3:0]      bus_fc = '0;
   logic [NCH-1:0]  cs;
   logic            berr, ack;

   always #(CLK_P/2) clk = ~clk;

   csd_top #(.NCH(NCH)) u_csd_top (.*);

   int checks = 0, fails = 0;
   logic [31:0] sh_base [NCH];
   logic [31:0] sh_mask [NCH];

   typedef struct { logic [NCH-1:0] cs; logic berr; int wt; string tag; } exp_t;
   exp_t q[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int ch, input bit sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1; reg_idx = IW'(ch); reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
      if (sel) sh_mask[ch] = d; else sh_base[ch] = d;
   endtask

   task automatic rd(input string tag, input int ch, input bit sel, input logic [31:0] exp);
      @(negedge clk);
      reg_idx = IW'(ch); reg_sel = sel; #1;
      chk(tag, reg_rdata, exp);
   endtask

   function automatic exp_t predict(input logic [31:0] a, input logic [3:0] f,
                                    input bit rw, input string tag);
      exp_t e;
      e.cs = '0; e.berr = 0; e.wt = -1; e.tag = tag;
      for (int i = 0; i < NCH; i++) begin
         logic [31:0] b, m;
         b = sh_base[i]; m = sh_mask[i];
         if (b[7] && (((a[31:8] ^ b[31:8]) & ~m[31:8]) == 0) &&
             (((f ^ b[3:0]) & ~m[3:0]) == 0) && !(b[6] && f[2:0] == 3'b111)) begin
            if (b[5] && !rw) e.berr = 1;
            else begin e.cs = NCH'(1) << i; e.wt = int'({b[4], m[5:4]}); end
            return e;
         end
      end
      return e;
   endfunction

   task automatic cyc(input logic [31:0] a, input logic [3:0] f, input bit rw, input string tag);
      @(negedge clk);
      q.push_back(predict(a, f, rw, tag));
      bus_addr = a; bus_fc = f; bus_rw = rw; bus_as = 1;
      repeat (HOLD) @(negedge clk);
      bus_as = 0;
      repeat (2) @(negedge clk);
   endtask

   // monitor
   initial begin
      int k = 0, ack_n = 0, ack_at = -1;
      bit have = 0;
      exp_t cur;
      forever begin
         @(posedge clk);
         if (bus_as && rst_n) k++; else k = 0;
         #1;
         if (k == 1) begin
            if (q.size() == 0) begin
               checks++; fails++; $display("FAIL R9 unexpected cycle actual=1 expected=0");
            end else begin
               cur = q.pop_front(); have = 1; ack_n = 0; ack_at = -1;
            end
         end
         if (have && k >= 1) begin
            if (ack) begin ack_n++; ack_at = k - 1; end
            chk({cur.tag, " cs"}, 32'(cs), 32'(cur.cs));
            chk({cur.tag, " berr"}, 32'(berr), 32'(cur.berr));
         end
         if (have && k == 0) begin
            chk({cur.tag, " R9 cs cleared"}, 32'(cs), 32'd0);
            chk({cur.tag, " R9 berr cleared"}, 32'(berr), 32'd0);
            chk({cur.tag, " R7 ack count"}, 32'(ack_n), (cur.wt >= 0) ? 32'd1 : 32'd0);
            if (cur.wt >= 0) chk({cur.tag, " R7 ack delay"}, 32'(ack_at), 32'(cur.wt));
            have = 0;
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NCH; i++) begin sh_base[i] = '0; sh_mask[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      chk("reset cs", 32'(cs), 0);
      chk("reset berr/ack", {30'd0, berr, ack}, 0);
      for (int i = 0; i < NCH; i++) begin
         wr(i, 0, 32'h0000_0000); wr(i, 1, 32'h0000_0000);
      end
      rd("R5 valid low", 0, 0, 32'h0);

      // R1/R7: ch0 1MB window, fc 5, dd=2
      wr(0, 0, 32'h1000_0085); wr(0, 1, 32'h000F_FF20);
      rd("R10 base rb", 0, 0, 32'h1000_0085);
      rd("R10 mask rb", 0, 1, 32'h000F_FF20);
      cyc(32'h1004_5678, 4'h5, 1, "R1 in window");
      cyc(32'h1010_0000, 4'h5, 1, "R1 outside");
      cyc(32'h1000_0000, 4'h1, 1, "R2 fc mismatch");
      // R2/R7: ch1 256B window, fc 1 with fc mask bit2, ext=1 dd=1
      wr(1, 0, 32'h2000_0091); wr(1, 1, 32'h0000_0014);
      cyc(32'h2000_00FF, 4'h1, 1, "R2 fc1 hit");
      cyc(32'h2000_0010, 4'h5, 1, "R2 fc5 hit via mask");
      cyc(32'h2000_0100, 4'h1, 1, "R1 256B edge");
      cyc(32'h2000_0010, 4'h3, 1, "R2 fc3 miss");
      // R3: ch2 fc 7 with mask bit3, nocpu
      wr(2, 0, 32'h3000_00C7); wr(2, 1, 32'h0000_0838);
      cyc(32'h3000_0000, 4'h7, 1, "R3 fc7 suppressed");
      cyc(32'h3000_0000, 4'hF, 1, "R3 fcF suppressed");
      wr(2, 0, 32'h3000_0087);
      cyc(32'h3000_0000, 4'hF, 1, "R3 fcF allowed");
      // R4: ch3 write protect, dd=0
      wr(3, 0, 32'h4000_00A2); wr(3, 1, 32'h0000_FF00);
      cyc(32'h4000_1200, 4'h2, 0, "R4 protected write");
      cyc(32'h4000_1200, 4'h2, 1, "R4 read ok");
      // extended delays and all dd codes
      for (int d = 0; d < 4; d++) begin
         wr(1, 1, 32'h0000_0004 | (d << 4));
         wr(1, 0, 32'h2000_0081);
         cyc(32'h2000_0000, 4'h1, 1, "R7 normal range");
         wr(1, 0, 32'h2000_0091);
         cyc(32'h2000_0000, 4'h1, 1, "R7 extended range");
      end
      // R8: overlapping windows ch0 and ch3
      wr(3, 0, 32'h1000_0085); wr(3, 1, 32'h000F_FF10);
      cyc(32'h1000_4000, 4'h5, 1, "R8 lowest wins");
      wr(0, 0, 32'h1000_0005);
      cyc(32'h1000_4000, 4'h5, 1, "R8/R5 ch0 invalid");
      wr(3, 0, 32'h1000_0025);
      cyc(32'h1000_4000, 4'h5, 0, "R5 all invalid");
      // R6: reset keeps fields, clears valid/nocpu
      wr(2, 0, 32'h3000_00F7);
      @(negedge clk); rst_n = 0;
      repeat (2) @(negedge clk); rst_n = 1;
      for (int i = 0; i < NCH; i++) sh_base[i] = sh_base[i] & ~32'hC0;
      rd("R6 base2 fields", 2, 0, 32'h3000_0037);
      rd("R6 mask2 kept", 2, 1, 32'h0000_0838);
      rd("R6 base1 fields", 1, 0, 32'h2000_0011);
      cyc(32'h2000_0000, 4'h1, 1, "R6 invalid after reset");
      wr(1, 0, 32'h2000_0081);
      cyc(32'h2000_0000, 4'h1, 1, "R6 kept timing");
      repeat (4) @(negedge clk);
      chk("R9 scoreboard drained", q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule